// File: doc/BRIEF.md
# Write Checksum and Self-Verify Tracker

This block follows every byte that a loader commits to memory. It keeps a 16-bit running sum of the committed data bytes. It also compares each byte read back from memory with the byte that was sent, and remembers any difference in a sticky verify-fail flag. A host-issued init command clears both the sum and the flag. A check command adds a 16-bit operand to the sum, and the host supplies the two's complement of everything it sent. The check passes only when the total wraps to zero and no mismatch has been seen.

A pass raises a request to write 00h into the non-volatile boot-mode flag location. In that location, FFh keeps the node in the loader and any other value lets the application run. The request holds until the memory port acknowledges it. The block does not model the memory itself or the parsing of incoming frames.

Both inputs are valid/ready streams. The first carries one commit beat per memory write: the byte written, the byte read back, and a marker for control-register traffic. The second carries one command per beat. A beat transfers on a rising clock edge when valid and ready are both high. The block holds both ready signals low only while a boot-flag write request is outstanding. It never drops a beat that it has accepted.

Top module: `cst_tracker`

## Requirements
- R1: After reset, `sum_o` is 0, `vfail_o` is 0, `pass_o`, `fail_o` and `bflag_req` are low, and both ready outputs are high.
- R2: Each accepted commit beat with `cm_is_ctrl`=0 adds `cm_wr_byte`, zero-extended to 16 bits, to the sum modulo 65536. The new sum is visible on `sum_o` after the accepting edge.
- R3: An accepted commit beat with `cm_is_ctrl`=1 changes neither the sum nor the verify flag, whatever its byte values.
- R4: An accepted data beat whose `cm_rd_byte` differs from `cm_wr_byte` sets `vfail_o`. The flag stays set through later beats until an init command clears it.
- R5: The command code 02h (init) clears the sum and the verify flag. A data beat accepted in the same cycle is counted after the clear, so the sum becomes that beat's byte.
- R6: The command code 03h (check) forms the sum plus the operand {`cmd_arg_hi`,`cmd_arg_lo`} modulo 65536. If that result is 0 and `vfail_o` is 0, `pass_o` is high for exactly the one cycle after acceptance. The check leaves the sum and the flag unchanged.
- R7: A check whose result is non-zero, or that finds `vfail_o` set, raises `fail_o` for the one cycle after acceptance. It issues no boot-flag request and leaves the sum and the flag unchanged.
- R8: A pass raises `bflag_req` in the same cycle as `pass_o`, with `bflag_data` = 00h. The request stays high until a cycle in which `bflag_ack` is high, and it drops after that edge. An acknowledge given while no request is outstanding has no effect.
- R9: While `bflag_req` is high, `cm_ready` and `cmd_ready` are low, so offered beats do not change the sum, the flag or the pulse outputs.
- R10: Any command code other than 02h and 03h changes nothing: the sum, the flag, the pulses and the request all stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cm_valid | input | 1 | Commit beat valid |
| cm_ready | output | 1 | Commit beat ready |
| cm_is_ctrl | input | 1 | Beat targets control registers (not counted) |
| cm_wr_byte | input | 8 | Byte sent to memory |
| cm_rd_byte | input | 8 | Byte read back after the write |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_code | input | 8 | Command code |
| cmd_arg_lo | input | 8 | Operand low byte |
| cmd_arg_hi | input | 8 | Operand high byte |
| sum_o | output | 16 | Running sum |
| vfail_o | output | 1 | Sticky verify-fail flag |
| pass_o | output | 1 | One-cycle check-pass pulse |
| fail_o | output | 1 | One-cycle check-fail pulse |
| bflag_req | output | 1 | Boot-flag clear write request |
| bflag_data | output | 8 | Value to write to the boot-flag location |
| bflag_ack | input | 1 | Memory port acknowledge |

## Verification
Two conditions are hard to reach from the ports. The first is a pass, which needs the exact two's-complement operand of a sum built from many beats. The second is a wrap of the 16-bit sum past 65535. The bench drives full sweeps of all 256 byte values and a long run of FFh bytes, and tracks the sum arithmetically so that it can offer both the exact and an off-by-one operand. Back-pressure is exercised by offering beats and commands while the boot-flag request waits for a delayed acknowledge.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_INIT, OP_CHECK} op_e;
endpackage

// File: rtl/cst_accum.sv
module cst_accum #(
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [BYTE_W-1:0] add_byte,
  output logic [SUM_W-1:0]  sum_q
);
  localparam int unsigned PAD = SUM_W - BYTE_W;

  logic [SUM_W-1:0] base, addend, sum_d;

  always_comb begin
    base   = clr ? '0 : sum_q;
    addend = add_en ? {{PAD{1'b0}}, add_byte} : '0;
    sum_d  = base + addend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en) |=> (sum_q == $past(sum_q))); // R3
endmodule

// File: rtl/cst_verify.sv
module cst_verify #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmp_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              fail_q
);
  logic miss, fail_d;

  always_comb begin
    miss   = cmp_en && (wr_byte != rd_byte);
    fail_d = (clr ? 1'b0 : fail_q) | miss;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b0;
    else        fail_q <= fail_d;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr) |=> fail_q); // R4
endmodule

// File: rtl/cst_judge.sv
module cst_judge
  import cst_pkg::*;
#(
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned CODE_W = 8,
  parameter logic [CODE_W-1:0] CMD_INIT  = 'h02,
  parameter logic [CODE_W-1:0] CMD_CHECK = 'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [SUM_W-1:0]  operand,
  input  logic [SUM_W-1:0]  sum_i,
  input  logic              vfail_i,
  input  logic              ack_i,
  output logic              cmd_ready,
  output logic              clr_o,
  output logic              pass_q,
  output logic              fail_q,
  output logic              req_q
);
  op_e              op;
  logic [SUM_W-1:0] total;
  logic             ok;

  assign cmd_ready = !req_q;

  always_comb begin
    op = OP_NONE;
    if (cmd_valid && cmd_ready) begin
      if (cmd_code == CMD_INIT)       op = OP_INIT;
      else if (cmd_code == CMD_CHECK) op = OP_CHECK;
    end
    total = sum_i + operand;
    ok    = (total == '0) && !vfail_i;
    clr_o = (op == OP_INIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pass_q <= (op == OP_CHECK) && ok;
      fail_q <= (op == OP_CHECK) && !ok;
      if ((op == OP_CHECK) && ok) req_q <= 1'b1;
      else if (ack_i)             req_q <= 1'b0;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q)); // R7
  AST_PASS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |=> !pass_q); // R6
  AST_PASS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> req_q); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> req_q); // R8
  AST_FAIL_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> !$rose(req_q)); // R7
endmodule

// File: rtl/cst_tracker.sv
module cst_tracker #(
  parameter int unsigned SUM_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CODE_W = 8,
  parameter logic [CODE_W-1:0] CMD_INIT  = 'h02,
  parameter logic [CODE_W-1:0] CMD_CHECK = 'h03,
  parameter logic [BYTE_W-1:0] RUN_VALUE = 'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_valid,
  output logic              cm_ready,
  input  logic              cm_is_ctrl,
  input  logic [BYTE_W-1:0] cm_wr_byte,
  input  logic [BYTE_W-1:0] cm_rd_byte,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [BYTE_W-1:0] cmd_arg_lo,
  input  logic [BYTE_W-1:0] cmd_arg_hi,
  output logic [SUM_W-1:0]  sum_o,
  output logic              vfail_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              bflag_req,
  output logic [BYTE_W-1:0] bflag_data,
  input  logic              bflag_ack
);
  localparam int unsigned OPND_W = 2 * BYTE_W;

  logic              data_beat, clr;
  logic [SUM_W-1:0]  operand;
  logic [OPND_W-1:0] opnd_raw;

  assign cm_ready   = !bflag_req;
  assign data_beat  = cm_valid && cm_ready && !cm_is_ctrl;
  assign opnd_raw   = {cmd_arg_hi, cmd_arg_lo};
  assign operand    = SUM_W'(opnd_raw);
  assign bflag_data = RUN_VALUE;

  cst_accum #(.SUM_W(SUM_W), .BYTE_W(BYTE_W)) accum_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .add_en(data_beat),
    .add_byte(cm_wr_byte), .sum_q(sum_o));

  cst_verify #(.BYTE_W(BYTE_W)) verify_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_en(data_beat),
    .wr_byte(cm_wr_byte), .rd_byte(cm_rd_byte), .fail_q(vfail_o));

  cst_judge #(.SUM_W(SUM_W), .CODE_W(CODE_W),
              .CMD_INIT(CMD_INIT), .CMD_CHECK(CMD_CHECK)) judge_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .operand(operand), .sum_i(sum_o), .vfail_i(vfail_o), .ack_i(bflag_ack),
    .cmd_ready(cmd_ready), .clr_o(clr), .pass_q(pass_o), .fail_q(fail_o),
    .req_q(bflag_req));

  AST_STALL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (bflag_req && !clr) |=> $stable(sum_o)); // R9
endmodule

// File: tb/cst_tracker_tb_top.sv
`timescale 1ns/1ps
module cst_tracker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cm_valid = 0, cm_is_ctrl = 0, cmd_valid = 0, bflag_ack = 0;
  logic [7:0] cm_wr_byte = 0, cm_rd_byte = 0, cmd_code = 0, cmd_arg_lo = 0, cmd_arg_hi = 0;
  logic cm_ready, cmd_ready, vfail_o, pass_o, fail_o, bflag_req;
  logic [15:0] sum_o;
  logic [7:0] bflag_data;

  int nvec = 0, nbad = 0;
  logic [15:0] exp_sum = 0;
  logic exp_vf = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cst_tracker dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic state_chk(input string tag);
    chk({tag, " sum"}, sum_o, exp_sum);
    chk({tag, " vflag"}, vfail_o, exp_vf);
  endtask

  task automatic commit(input logic ctrl, input logic [7:0] wr, input logic [7:0] rd);
    @(negedge clk);
    cm_valid = 1; cm_is_ctrl = ctrl; cm_wr_byte = wr; cm_rd_byte = rd;
    @(posedge clk);
    @(negedge clk);
    cm_valid = 0;
    if (!ctrl) begin
      exp_sum = exp_sum + {8'h00, wr};
      if (wr != rd) exp_vf = 1;
    end
  endtask

  // issue a command; returns pulses seen one cycle after acceptance
  task automatic command(input logic [7:0] code, input logic [15:0] op,
                         output logic p, output logic f);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code; cmd_arg_lo = op[7:0]; cmd_arg_hi = op[15:8];
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    p = pass_o; f = fail_o;
  endtask

  task automatic ack_after(input int waitn);
    for (int i = 0; i < waitn; i++) begin
      chk("R8 req held", bflag_req, 1);
      chk("R9 cmd stalled", cmd_ready, 0);
      chk("R9 commit stalled", cm_ready, 0);
      chk("R6 pass one cycle", pass_o, (i == 0) ? 1 : 0);
      cm_valid = 1; cm_is_ctrl = 0; cm_wr_byte = 8'h5A; cm_rd_byte = 8'h00;
      cmd_valid = 1; cmd_code = 8'h02;
      @(negedge clk);
    end
    cm_valid = 0; cmd_valid = 0;
    state_chk("R9 stalled beats");
    bflag_ack = 1;
    @(negedge clk);
    bflag_ack = 0;
    chk("R8 req drops after ack", bflag_req, 0);
    chk("R8 ready back", cmd_ready, 1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin : main
    logic p, f;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sum", sum_o, 0); chk("R1 vflag", vfail_o, 0);
    chk("R1 pass", pass_o, 0); chk("R1 fail", fail_o, 0);
    chk("R1 req", bflag_req, 0); chk("R1 cm_ready", cm_ready, 1);
    chk("R1 cmd_ready", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);

    // R2 sweep of every byte value, R3 control beats interleaved
    for (int v = 0; v < 256; v++) begin
      commit(0, v[7:0], v[7:0]);
      state_chk("R2 data sweep");
      commit(1, ~v[7:0], v[7:0]);
      state_chk("R3 control beat ignored");
    end
    // R7 off-by-one operand fails
    command(8'h03, (~exp_sum) , p, f);
    chk("R7 fail pulse", f, 1); chk("R7 no pass", p, 0);
    chk("R7 no req", bflag_req, 0); state_chk("R7 state kept");
    @(negedge clk);
    chk("R7 pulse one cycle", fail_o, 0);
    // R6 exact complement passes
    command(8'h03, 16'(-exp_sum), p, f);
    chk("R6 pass pulse", p, 1); chk("R6 no fail", f, 0);
    chk("R8 req with pass", bflag_req, 1); chk("R8 data 00h", bflag_data, 8'h00);
    state_chk("R6 state kept");
    ack_after(4);
    // R8 stray ack
    bflag_ack = 1; @(negedge clk); bflag_ack = 0; @(negedge clk);
    chk("R8 stray ack", bflag_req, 0); chk("R8 stray ack pass", pass_o, 0);

    // R10 undefined codes
    for (int c = 0; c < 256; c++) begin
      if (c == 2 || c == 3) continue;
      command(c[7:0], 16'(-exp_sum), p, f);
      chk("R10 no pass", p, 0); chk("R10 no fail", f, 0);
      chk("R10 no req", bflag_req, 0);
    end
    state_chk("R10 state kept");

    // R5 init clears
    command(8'h02, 16'h0000, p, f);
    exp_sum = 0; exp_vf = 0;
    state_chk("R5 init");
    // R2 wrap: 300 beats of FFh
    for (int i = 0; i < 300; i++) commit(0, 8'hFF, 8'hFF);
    state_chk("R2 wraparound");
    command(8'h03, 16'(-exp_sum), p, f);
    chk("R6 pass after wrap", p, 1);
    ack_after(1);

    // R4 mismatch sweep, flag sticky
    command(8'h02, 16'h0000, p, f);
    exp_sum = 0; exp_vf = 0;
    for (int v = 0; v < 256; v++) begin
      commit(0, v[7:0], v[7:0] ^ 8'h01 ^ ((v == 0) ? 8'h00 : 8'h01));
      state_chk("R4 sweep");
      commit(1, v[7:0], ~v[7:0]);
      state_chk("R3 control mismatch ignored");
    end
    command(8'h03, 16'(-exp_sum), p, f);
    chk("R7 flag blocks pass", f, 1); chk("R7 flag no pass", p, 0);
    state_chk("R7 state kept flag");
    // R5 init together with a data beat
    @(negedge clk);
    cmd_valid = 1; cmd_code = 8'h02; cm_valid = 1; cm_is_ctrl = 0;
    cm_wr_byte = 8'h3C; cm_rd_byte = 8'h3C;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0; cm_valid = 0;
    exp_sum = 16'h003C; exp_vf = 0;
    state_chk("R5 init with beat");
    command(8'h03, 16'hFFC4, p, f);
    chk("R6 pass after init", p, 1);
    ack_after(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule